// File: doc/BRIEF.md
# Burst SPI Master Engine

This block is the serial core of an SPI master. A set of configuration inputs chooses the clock mode, which chip select to drive and at which polarity, a gating rule on an external ready line, a power-of-two clock divider, the word length, the number of words in a burst and an idle gap between words. A one-cycle start pulse launches a burst. The engine then pulls each outgoing word from a valid/ready transmit port, shifts it out most significant bit first while shifting the incoming line in, and presents every received word on a one-cycle receive strobe.

The chip select is held for exactly one burst. It stays asserted through the inter-word gaps and while the transmit side has no word ready. During such a stall the serial clock rests at its idle level, so a late word does not wedge the transfer. A single-cycle completion pulse marks the end of the burst. Configuration is captured on the start pulse. While the engine is idle, the idle levels of the clock and of the chip selects follow the live polarity inputs.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, and on any cycle after `cfg_enable` was low at the previous edge, the engine is idle. In that state every chip select sits at its inactive level, `sclk` equals `cfg_cpol`, and `tx_ready`, `rx_valid` and `done` are low. A start pulse while disabled has no effect. Clearing the enable in mid-burst ends the burst without a `done` pulse.
- R2: One serial bit lasts 2^(`cfg_rate`+2) core clock cycles, made of two half periods of 2^(`cfg_rate`+1) cycles each. For rate 0 this is 4 cycles and for rate 7 it is 512.
- R3: `sclk` idles at `cfg_cpol`. With `cfg_cpha`=0 a bit is put on `mosi` before the leading edge and `miso` is sampled on the leading edge. With `cfg_cpha`=1 a bit is put out at the leading edge and sampled on the trailing edge.
- R4: A word has `cfg_bits_m1`+1 bits; lengths of 8, 16, 24 and 32 are supported. The engine sends bits [`cfg_bits_m1`:0] of `tx_data`, most significant first. `rx_data` carries the received bits right-aligned, with zeros above them.
- R5: One start pulse transfers `cfg_words` words. A value of 0 transfers 128 words.
- R6: During a burst only output `cs_o[cfg_cs_sel]` is active. It is active high when `cfg_cs_high`=1 and active low when it is 0. It asserts when the first word is requested and stays asserted, without a break, until the burst ends.
- R7: `cfg_rdy_mode` gates the start of a burst. 0 (and 3) ignores `rdy_in`. 1 waits for a high-to-low transition of `rdy_in`; a level held low or a rising edge does not start the burst. 2 waits while `rdy_in` is low.
- R8: With `tx_valid` held high, successive `rx_valid` pulses are 2^(`cfg_rate`+2)·bits + 1 + `cfg_gap` cycles apart. This means `cfg_gap` idle cycles are added between words, and a gap of 0 adds none.
- R9: While `tx_valid` is low at a word boundary, the engine waits. The chip select stays asserted, `sclk` stays at its idle level, and no word is consumed or received.
- R10: `rx_valid` pulses for one cycle per word. `done` pulses exactly once per completed burst, in the same cycle as the last word's `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; low forces idle |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling-edge select |
| cfg_cs_high | input | 1 | Chip-select active level (1 = high) |
| cfg_cs_sel | input | 2 | Index of the chip select to drive |
| cfg_rdy_mode | input | 2 | Ready-line gating rule |
| cfg_rate | input | 3 | Clock divider exponent |
| cfg_bits_m1 | input | 6 | Bits per word minus one |
| cfg_words | input | 7 | Words per burst (0 = 128) |
| cfg_gap | input | 15 | Idle cycles between words |
| start | input | 1 | One-cycle burst launch |
| tx_data | input | 32 | Outgoing word |
| tx_valid | input | 1 | Outgoing word available |
| tx_ready | output | 1 | Word taken when high with tx_valid |
| rx_data | output | 32 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| done | output | 1 | One-cycle end-of-burst pulse |
| rdy_in | input | 1 | External ready line |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip selects |

## Verification
Two events can land on the same cycle: the receive strobe for the final word and the completion pulse. The chip select also deasserts on that cycle. Every burst in the mode, length and rate sweep ends this way. The bench counts completion pulses that arrive without a receive strobe, and it flags a chip select that drops before the completion pulse is seen. A behavioural slave follows the serial clock edges according to the clock mode. Its captured words and its replies are compared word by word, which exercises sampling and shifting together on every edge.

// File: rtl/spib_pkg.sv
// Shared types for the burst SPI master engine.
// Assumes: included first in compile order.
package spib_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_LOAD,
        S_SHIFT,
        S_GAP
    } spib_state_e;

    localparam logic [1:0] RDY_NONE  = 2'd0;
    localparam logic [1:0] RDY_FALL  = 2'd1;
    localparam logic [1:0] RDY_LEVEL = 2'd2;
endpackage

// File: rtl/spib_half_tick.sv
// Half-period tick generator for the serial clock.
// Counts core cycles while run is high and pulses tick on the last cycle of
// each half period of 2^(rate+1) cycles. Clears whenever run is low.
// Assumes: rate is stable while run is high.
module spib_half_tick #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Last count value of one half period.
    always_comb half_m1 = (CNT_W'(1) << (int'(rate) + 1)) - CNT_W'(1);

    assign tick = run && (cnt == half_m1);

    // Half-period counter, restarted outside of shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2: the counter never passes the end of a half period.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half_m1));
endmodule

// File: rtl/spib_rdy_gate.sv
// Burst start gate on the external ready line.
// Produces go when the selected rule allows the burst to begin: always,
// on a sampled falling edge, or while the line is high.
// Assumes: rdy_in is synchronous to clk.
module spib_rdy_gate
    import spib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rdy_in,
    output logic       go
);
    logic rdy_q;

    // Previous-cycle copy of the ready line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= rdy_in;
    end

    // Rule selection.
    always_comb begin
        unique case (mode)
            RDY_FALL:  go = rdy_q && !rdy_in;
            RDY_LEVEL: go = rdy_in;
            default:   go = 1'b1;
        endcase
    end

    // R7: in edge mode, permission only follows a high-to-low transition.
    p_fall_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RDY_FALL && go) |-> $fell(rdy_in));
endmodule

// File: rtl/spib_cs_drive.sv
// Chip-select output stage.
// Drives the selected line to the active level while active is high and
// holds every other line at the inactive level.
// Assumes: sel is stable for the whole burst.
module spib_cs_drive #(
    parameter int NCS = 4
) (
    input  logic                   active,
    input  logic [$clog2(NCS)-1:0] sel,
    input  logic                   act_high,
    output logic [NCS-1:0]         cs_o
);
    localparam int SEL_W = $clog2(NCS);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        // One output line per select index.
        assign cs_o[i] = (active && (sel == SEL_W'(i))) ? act_high : ~act_high;
    end
endmodule

// File: rtl/spi_burst_master.sv
// Burst SPI master engine top.
// Captures the configuration on start and waits for the ready rule. It then
// moves cfg_words words between the valid/ready transmit port and the
// receive strobe, and pulses done after the last word.
// Assumes: synchronous active-low reset; miso is synchronous to clk.
module spi_burst_master
    import spib_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 6,
    parameter int BURST_W = 7,
    parameter int RATE_W  = 3,
    parameter int GAP_W   = 15,
    parameter int NCS     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic                   cfg_cpol,
    input  logic                   cfg_cpha,
    input  logic                   cfg_cs_high,
    input  logic [$clog2(NCS)-1:0] cfg_cs_sel,
    input  logic [1:0]             cfg_rdy_mode,
    input  logic [RATE_W-1:0]      cfg_rate,
    input  logic [LEN_W-1:0]       cfg_bits_m1,
    input  logic [BURST_W-1:0]     cfg_words,
    input  logic [GAP_W-1:0]       cfg_gap,
    input  logic                   start,
    input  logic [DATA_W-1:0]      tx_data,
    input  logic                   tx_valid,
    output logic                   tx_ready,
    output logic [DATA_W-1:0]      rx_data,
    output logic                   rx_valid,
    output logic                   done,
    input  logic                   rdy_in,
    output logic                   sclk,
    output logic                   mosi,
    input  logic                   miso,
    output logic [NCS-1:0]         cs_o
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int WCNT_W = BURST_W + 1;
    localparam int SEL_W  = $clog2(NCS);

    spib_state_e         st;
    logic                cpol_l, cpha_l, csh_l;
    logic [SEL_W-1:0]    sel_l;
    logic [1:0]          mode_l;
    logic [RATE_W-1:0]   rate_l;
    logic [IDX_W-1:0]    blen_l;
    logic [GAP_W-1:0]    gap_l, gap_cnt;
    logic [WCNT_W-1:0]   words_left;
    logic [IDX_W-1:0]    bitcnt;
    logic                ph;
    logic [DATA_W-1:0]   tx_sh, rx_sh;
    logic [DATA_W-1:0]   rx_data_q;
    logic                rx_valid_q, done_q;
    logic [IDX_W-1:0]    bits_eff;
    logic [WCNT_W-1:0]   burst_eff;
    logic                tick, go, in_burst, act_high;

    // Word length clamped to the data path width.
    always_comb bits_eff = (int'(cfg_bits_m1) >= DATA_W) ? IDX_W'(DATA_W - 1)
                                                         : cfg_bits_m1[IDX_W-1:0];
    // Word count, with zero meaning the largest burst.
    always_comb burst_eff = (cfg_words == '0) ? WCNT_W'(1 << BURST_W)
                                              : WCNT_W'(cfg_words);

    spib_half_tick #(.RATE_W(RATE_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st == S_SHIFT),
        .rate (rate_l),
        .tick (tick)
    );

    spib_rdy_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_l),
        .rdy_in(rdy_in),
        .go    (go)
    );

    // Burst sequencer: capture, gating, word load, bit shifting, gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            cpol_l     <= 1'b0;
            cpha_l     <= 1'b0;
            csh_l      <= 1'b0;
            sel_l      <= '0;
            mode_l     <= RDY_NONE;
            rate_l     <= '0;
            blen_l     <= '0;
            gap_l      <= '0;
            gap_cnt    <= '0;
            words_left <= '0;
            bitcnt     <= '0;
            ph         <= 1'b0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            done_q     <= 1'b0;
            if (!cfg_enable) begin
                st <= S_IDLE;
            end else begin
                unique case (st)
                    S_IDLE: if (start) begin
                        cpol_l     <= cfg_cpol;
                        cpha_l     <= cfg_cpha;
                        csh_l      <= cfg_cs_high;
                        sel_l      <= cfg_cs_sel;
                        mode_l     <= cfg_rdy_mode;
                        rate_l     <= cfg_rate;
                        blen_l     <= bits_eff;
                        gap_l      <= cfg_gap;
                        words_left <= burst_eff;
                        st         <= S_WAIT;
                    end
                    S_WAIT: if (go) st <= S_LOAD;
                    S_LOAD: if (tx_valid) begin
                        tx_sh  <= tx_data;
                        rx_sh  <= '0;
                        bitcnt <= blen_l;
                        ph     <= 1'b0;
                        st     <= S_SHIFT;
                    end
                    S_SHIFT: if (tick) begin
                        if (!ph) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], miso};
                            ph    <= 1'b1;
                        end else begin
                            ph <= 1'b0;
                            if (bitcnt == '0) begin
                                rx_data_q  <= rx_sh;
                                rx_valid_q <= 1'b1;
                                words_left <= words_left - WCNT_W'(1);
                                if (words_left == WCNT_W'(1)) begin
                                    done_q <= 1'b1;
                                    st     <= S_IDLE;
                                end else if (gap_l != '0) begin
                                    gap_cnt <= gap_l - GAP_W'(1);
                                    st      <= S_GAP;
                                end else begin
                                    st <= S_LOAD;
                                end
                            end else begin
                                bitcnt <= bitcnt - IDX_W'(1);
                                tx_sh  <= tx_sh << 1;
                            end
                        end
                    end
                    S_GAP: begin
                        if (gap_cnt == '0) st <= S_LOAD;
                        else               gap_cnt <= gap_cnt - GAP_W'(1);
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // Output decode from sequencer state.
    assign in_burst = (st == S_LOAD) || (st == S_SHIFT) || (st == S_GAP);
    assign act_high = (st == S_IDLE) ? cfg_cs_high : csh_l;
    assign sclk     = (st == S_SHIFT) ? (cpol_l ^ ph ^ cpha_l)
                    : ((st == S_IDLE) ? cfg_cpol : cpol_l);
    assign mosi     = (st == S_SHIFT) ? tx_sh[blen_l] : 1'b0;
    assign tx_ready = (st == S_LOAD) && cfg_enable;
    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;
    assign done     = done_q;

    spib_cs_drive #(.NCS(NCS)) u_cs (
        .active  (in_burst),
        .sel     (sel_l),
        .act_high(act_high),
        .cs_o    (cs_o)
    );

    // R1: a low enable returns the sequencer to idle on the next edge.
    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (st == S_IDLE));

    // R10: completion never arrives without the last word's strobe.
    p_done_with_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rx_valid);

    // R6: at most one chip select is at its active level.
    p_cs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_high ? cs_o : ~cs_o));

    // R9: a missing word freezes the sequencer and the serial clock.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && st == S_LOAD && !tx_valid) |=> (st == S_LOAD && $stable(sclk)));

    // R7: level mode keeps waiting while the ready line is low.
    p_wait_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && st == S_WAIT && mode_l == RDY_LEVEL && !rdy_in) |=> (st == S_WAIT));

    // R4: the bit counter stays within the configured word.
    p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SHIFT) |-> (bitcnt <= blen_l));
endmodule

// File: tb/tb_spi_burst_master.sv
`timescale 1ns/1ps
module tb_spi_burst_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_high = 1'b0;
    logic [1:0]  cfg_cs_sel = '0, cfg_rdy_mode = '0;
    logic [2:0]  cfg_rate = '0;
    logic [5:0]  cfg_bits_m1 = 6'd7;
    logic [6:0]  cfg_words = 7'd1;
    logic [14:0] cfg_gap = '0;
    logic        start = 1'b0, tx_valid = 1'b1, rdy_in = 1'b0;
    logic [31:0] tx_data, rx_data;
    logic        tx_ready, rx_valid, done, sclk, mosi, miso;
    logic [3:0]  cs_o;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, pop_n = 0, base = 0, nb;
    int rx_n = 0, done_n = 0, done_alone = 0;
    bit mon_on = 0, cs_bad = 0, cs_drop = 0, sclk_bad = 0, seen_act = 0;
    logic [31:0] got [0:129];
    int          rx_cyc [0:129];
    logic [31:0] cap [0:129];
    int          s_e = 0, s_g = 0;
    logic        prev_sclk = 1'b0, miso_r = 1'b0, slave_act;

    always #2.5 clk = ~clk;

    spi_burst_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs_high(cfg_cs_high), .cfg_cs_sel(cfg_cs_sel),
        .cfg_rdy_mode(cfg_rdy_mode), .cfg_rate(cfg_rate), .cfg_bits_m1(cfg_bits_m1),
        .cfg_words(cfg_words), .cfg_gap(cfg_gap), .start(start), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .done(done), .rdy_in(rdy_in), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
    );

    function automatic logic [31:0] txw(int i);
        return 32'h5A0F_3C96 ^ (32'(i + 1) * 32'h0102_0409);
    endfunction
    function automatic logic [31:0] resp(int w);
        return 32'hC3A5_1E69 ^ (32'(w) * 32'h9E37_79B9);
    endfunction
    function automatic logic bit_at(int e);
        logic [31:0] r;
        r = resp(e / nb);
        return r[nb - 1 - (e % nb)];
    endfunction
    function automatic logic [31:0] mask_of(int bits);
        longint m;
        m = (longint'(1) << bits) - 1;
        return m[31:0];
    endfunction

    always_comb nb = int'(cfg_bits_m1) + 1;
    assign tx_data   = txw(pop_n);
    assign miso      = miso_r;
    assign slave_act = (cs_o[cfg_cs_sel] === cfg_cs_high);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_valid && tx_ready) pop_n <= pop_n + 1;
    end

    // Behavioural slave: replies resp(word), captures mosi into cap.
    always @(posedge slave_act) begin
        s_e = 0;
        s_g = 0;
        for (int i = 0; i < 130; i++) cap[i] = '0;
        if (!cfg_cpha) miso_r = bit_at(0);
    end
    always @(sclk) begin
        if (slave_act && sclk !== prev_sclk) begin
            if (sclk != cfg_cpol) begin
                if (!cfg_cpha) begin
                    if (s_g / nb < 130) cap[s_g / nb][nb - 1 - (s_g % nb)] = mosi;
                    s_g++;
                end else begin
                    miso_r = bit_at(s_e);
                    s_e++;
                end
            end else begin
                if (!cfg_cpha) begin
                    s_e++;
                    miso_r = bit_at(s_e);
                end else begin
                    if (s_g / nb < 130) cap[s_g / nb][nb - 1 - (s_g % nb)] = mosi;
                    s_g++;
                end
            end
        end
        prev_sclk = sclk;
    end

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_n < 130) begin
                got[rx_n]    = rx_data;
                rx_cyc[rx_n] = cyc;
                rx_n++;
            end
            if (done) begin
                done_n++;
                if (!rx_valid) done_alone++;
            end
            if (mon_on) begin
                for (int j = 0; j < 4; j++)
                    if (j != int'(cfg_cs_sel) && cs_o[j] == cfg_cs_high) cs_bad = 1;
                if (slave_act) seen_act = 1;
                else begin
                    if (sclk !== cfg_cpol) sclk_bad = 1;
                    if (seen_act && done_n == 0) cs_drop = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic setup(input bit pol, input bit pha, input int bits, input int rate,
                         input int words, input int gap, input int sel, input bit csh,
                         input int mode);
        cfg_cpol = pol; cfg_cpha = pha; cfg_bits_m1 = 6'(bits - 1);
        cfg_rate = 3'(rate); cfg_words = 7'(words); cfg_gap = 15'(gap);
        cfg_cs_sel = 2'(sel); cfg_cs_high = csh; cfg_rdy_mode = 2'(mode);
        cfg_enable = 1'b1;
        step(2);
    endtask

    task automatic launch();
        base = pop_n; rx_n = 0; done_n = 0; done_alone = 0;
        cs_bad = 0; cs_drop = 0; sclk_bad = 0; seen_act = 0; mon_on = 1;
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic await_done(input int limit);
        int k = 0;
        while (done_n == 0 && k < limit) begin
            step(1);
            k++;
        end
        chk(done_n != 0, "R10", "burst end seen before timeout", done_n, 1);
        step(2);
        mon_on = 0;
    endtask

    task automatic verify(input int words, input int bits);
        logic [31:0] m;
        m = mask_of(bits);
        chk(rx_n == words, "R5", "words received", rx_n, words);
        for (int k = 0; k < words; k++) begin
            chk(got[k] == (resp(k) & m), "R3,R4", "received word",
                longint'(got[k]), longint'(resp(k) & m));
            chk(cap[k] == (txw(base + k) & m), "R3,R4", "word seen by slave",
                longint'(cap[k]), longint'(txw(base + k) & m));
        end
        chk(done_n == 1 && done_alone == 0, "R10", "done pulses / done without rx",
            longint'(done_n * 100 + done_alone), 100);
        chk(!cs_bad && seen_act && !cs_drop, "R6", "cs bad/seen/dropped",
            longint'({cs_bad, seen_act, cs_drop}), 3'b010);
        chk(!sclk_bad, "R3", "sclk away from idle without cs", sclk_bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        chk(cs_o == 4'hF, "R1", "cs in reset", cs_o, 4'hF);
        chk(sclk == 1'b0 && tx_ready == 1'b0, "R1", "sclk/tx_ready in reset",
            {sclk, tx_ready}, 0);
        chk(rx_valid == 1'b0 && done == 1'b0, "R1", "rx_valid/done in reset",
            {rx_valid, done}, 0);
        rst_n = 1'b1;
        cfg_cs_high = 1'b1; cfg_cpol = 1'b1; cfg_enable = 1'b1;
        step(2);
        chk(cs_o == 4'h0 && sclk == 1'b1, "R1", "idle levels follow polarity",
            {cs_o, sclk}, 1);

        // Mode, length and rate sweep.
        for (int pol = 0; pol < 2; pol++)
            for (int pha = 0; pha < 2; pha++)
                for (int bi = 1; bi <= 4; bi++)
                    for (int rt = 0; rt < 2; rt++) begin
                        setup(pol[0], pha[0], 8 * bi, rt, 3, 0, (bi + rt) % 4,
                              pha[0] ^ rt[0], 0);
                        launch();
                        await_done(5000);
                        verify(3, 8 * bi);
                    end

        // Word spacing versus rate and gap.
        for (int t = 0; t < 4; t++) begin
            int rt, gp, bits, sp;
            rt   = (t == 3) ? 7 : 2;
            gp   = (t == 1) ? 5 : ((t == 2) ? 300 : 0);
            bits = 8;
            sp   = (1 << (rt + 2)) * bits + 1 + gp;
            setup(0, 1, bits, rt, 3, gp, 1, 0, 0);
            launch();
            await_done(20000);
            chk(rx_cyc[1] - rx_cyc[0] == sp, (gp != 0) ? "R8" : "R2", "word spacing",
                rx_cyc[1] - rx_cyc[0], sp);
            chk(rx_cyc[2] - rx_cyc[1] == sp, "R8", "word spacing 2",
                rx_cyc[2] - rx_cyc[1], sp);
            verify(3, bits);
        end
        setup(1, 0, 16, 0, 2, 0, 2, 1, 0);
        launch();
        await_done(2000);
        chk(rx_cyc[1] - rx_cyc[0] == 65, "R2", "rate 0 spacing", rx_cyc[1] - rx_cyc[0], 65);

        // Burst length field 0.
        setup(0, 1, 8, 0, 0, 0, 3, 1, 0);
        launch();
        await_done(8000);
        verify(128, 8);

        // Ready gating: level mode.
        rdy_in = 1'b0;
        setup(0, 0, 8, 0, 2, 0, 0, 0, 2);
        launch();
        step(40);
        chk(pop_n == base && !slave_act, "R7", "level mode held while low",
            pop_n - base, 0);
        rdy_in = 1'b1;
        await_done(2000);
        verify(2, 8);

        // Ready gating: falling-edge mode.
        setup(1, 0, 8, 0, 2, 0, 1, 0, 1);
        launch();
        step(40);
        chk(pop_n == base && !slave_act, "R7", "edge mode held while high",
            pop_n - base, 0);
        rdy_in = 1'b0;
        await_done(2000);
        verify(2, 8);
        launch();
        step(40);
        chk(pop_n == base, "R7", "edge mode held while low", pop_n - base, 0);
        rdy_in = 1'b1;
        step(5);
        chk(pop_n == base && !slave_act, "R7", "rising edge does not start",
            pop_n - base, 0);
        rdy_in = 1'b0;
        await_done(2000);
        verify(2, 8);

        // Ready ignored in mode 0.
        setup(0, 1, 16, 0, 2, 0, 2, 1, 0);
        launch();
        await_done(2000);
        verify(2, 16);

        // Transmit stall: before the first word and between words.
        tx_valid = 1'b0;
        setup(0, 0, 8, 0, 3, 0, 1, 0, 0);
        launch();
        step(30);
        chk(slave_act && sclk == 1'b0 && pop_n == base, "R9", "stall before first word",
            {slave_act, sclk, 1'(pop_n != base)}, 3'b100);
        tx_valid = 1'b1;
        for (int k = 0; k < 2000 && rx_n == 0; k++) step(1);
        tx_valid = 1'b0;
        step(25);
        chk(rx_n == 1 && slave_act && sclk == 1'b0, "R9", "stall between words",
            rx_n, 1);
        tx_valid = 1'b1;
        await_done(2000);
        verify(3, 8);

        // Enable cleared mid-burst, then start while disabled.
        setup(1, 1, 32, 3, 4, 0, 2, 1, 0);
        launch();
        step(100);
        chk(slave_act, "R6", "cs active mid-burst", slave_act, 1);
        mon_on = 0;
        cfg_enable = 1'b0;
        step(1);
        chk(cs_o == 4'h0 && sclk == 1'b1, "R1", "abort returns to idle levels",
            {cs_o, sclk}, 1);
        step(60);
        chk(done_n == 0, "R1", "no done after abort", done_n, 0);
        base = pop_n;
        start = 1'b1;
        step(1);
        start = 1'b0;
        step(30);
        chk(pop_n == base && cs_o == 4'h0, "R1", "start ignored while disabled",
            pop_n - base, 0);
        setup(1, 1, 8, 1, 2, 3, 0, 0, 0);
        launch();
        await_done(2000);
        verify(2, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule